// File: doc/BRIEF.md
# Multiplexed LCD Frame Sequencer

This block generates the digital timing for a segment LCD with one to four backplanes. A phase divider breaks the system clock into backplane phases. A small state machine walks those phases through two half-frames of opposite polarity, so the panel sees no net DC. In each phase the block picks one row of the display memory and turns every backplane and segment into a 2-bit level code. A downstream analog stage turns each code into one tap of the bias ladder: 0 is ground, 1 and 2 are the lower and upper intermediate taps, and 3 is the full LCD supply. Mode, rate, bank, enable and blink settings arrive as plain register inputs. The whole display memory arrives as a flat vector, with the bit for row r and segment s at index r*NSEG+s.

The state machine has three states. ST_OFF is entered at reset; every output sits at code 0 and the wired sync line is released. ST_HALF_A is the first half-frame and ST_HALF_B is the second. The transitions are:
- OFF_TO_A: the first phase period expires.
- A_TO_B: the last active phase of half A ends.
- B_TO_A: the last active phase of half B ends. This is the frame boundary.
- ANY_TO_B_LAST: the shared sync line is seen low while this block is not pulling it. The block jumps to the last phase of half B with a fresh phase timer.

A device pulls the shared line for the whole of its last active backplane phase in half B and watches the line at all other times. In a cascade, the first device to pull the line therefore sets the phase for the others.

Top module: `lcd_frame_seq`

## Requirements
- R1: After reset, every backplane and segment code is 0 and sync_oe is 0 for the first full phase period (PH_DIV_SLOW clocks when rate_fast=0, PH_DIV_FAST when rate_fast=1).
- R2: Each backplane phase lasts PH_DIV_SLOW clocks when rate_fast=0 and PH_DIV_FAST clocks when rate_fast=1. Phases run 0..N-1 in half A, then 0..N-1 in half B, then repeat, where N = drive_mode+1.
- R3: drive_mode selects the number of active backplanes: 0=static, 1=two, 2=three, 3=four. The backplane whose index equals the current phase gets code 3 in half A and code 0 in half B. Every other backplane, active or unused, gets code 1 in half A and code 2 in half B. bp_lvl[2b+1:2b] carries backplane b.
- R4: A segment whose bit in the current row is 1 is driven opposite to the selected backplane: code 0 in half A, code 3 in half B. A segment whose bit is 0 takes code 2 in half A and code 1 in half B in multiplex modes, and copies backplane 0 in static mode. seg_lvl[2s+1:2s] carries segment s.
- R5: The row shown in phase p is row p. With bank_alt=1, static mode shows row 2 instead of row 0, and two-backplane mode shows rows 2 and 3 instead of rows 0 and 1. bank_alt has no effect in three- and four-backplane modes.
- R6: With disp_en=0, every segment takes its "bit is 0" code, and the backplanes keep running unchanged.
- R7: With blink_sel=0 the display is always shown. With blink_sel=k (1..3), it is shown for BLINK_BASE<<(k-1) frames and blanked as in R6 for the same number of frames, alternating, starting shown at reset.
- R8: sync_oe is 1 exactly during the last active phase (phase N-1) of half B and is 0 otherwise.
- R9: If sync_in is 1 while sync_oe is 0, the block enters the last phase of half B at the next edge, with the phase timer restarted. sync_oe is therefore 1 from that edge for one full phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drive_mode | input | 2 | Active backplanes minus one |
| rate_fast | input | 1 | 1 selects the shorter phase period |
| bank_alt | input | 1 | Selects the alternate display rows in static and two-backplane modes |
| disp_en | input | 1 | 0 blanks all segments |
| blink_sel | input | 2 | Blink period select; 0 disables blinking |
| ram_data | input | 4*NSEG | Display memory; bit r*NSEG+s is row r, segment s |
| sync_in | input | 1 | Level of the shared sync line (1 = pulled) |
| sync_oe | output | 1 | 1 pulls the shared open-drain sync line |
| bp_lvl | output | 8 | Level codes for four backplanes, 2 bits each |
| seg_lvl | output | 2*NSEG | Level codes for the segments, 2 bits each |

## Verification
The bench sweeps every drive mode against both rates and both bank settings. Each cycle it compares every output code against a position derived arithmetically from the edge count. Phase wrap errors in three-backplane mode would show up as a stray fourth phase, and a bank swap applied outside static and two-backplane modes would show rows 2 and 3 in the wrong phases. Blanking and all three blink periods are run across several frame boundaries, where an off-by-one frame counter toggles a frame early or late. A realignment pulse injected mid-frame in static and four-backplane modes checks that the block jumps straight to its last phase with a restarted timer; a block that kept its old timer would end that phase early.

// File: rtl/lcd_seq_pkg.sv
`timescale 1ns/1ps
package lcd_seq_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_HALF_A = 2'd1,
        ST_HALF_B = 2'd2
    } seq_state_t;

    localparam int NUM_BP = 4;

    localparam logic [1:0] LV_GND = 2'd0;
    localparam logic [1:0] LV_LO  = 2'd1;
    localparam logic [1:0] LV_HI  = 2'd2;
    localparam logic [1:0] LV_TOP = 2'd3;
endpackage

// File: rtl/lcd_phase_timer.sv
`timescale 1ns/1ps
module lcd_phase_timer #(
    parameter int DIV_SLOW = 8,
    parameter int DIV_FAST = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    input  logic restart,
    output logic tick
);
    localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int CW      = $clog2(DIV_MAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lcd_blink_gen.sv
`timescale 1ns/1ps
module lcd_blink_gen #(
    parameter int BLINK_BASE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] blink_sel,
    input  logic       frame_end,
    output logic       visible
);
    localparam int BW = $clog2(BLINK_BASE * 4 + 1);

    logic [BW-1:0] frames;
    logic [BW-1:0] period;

    always_comb begin
        unique case (blink_sel)
            2'd1:    period = BW'(BLINK_BASE);
            2'd2:    period = BW'(BLINK_BASE * 2);
            default: period = BW'(BLINK_BASE * 4);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || blink_sel == 2'd0) begin
            frames  <= '0;
            visible <= 1'b1;
        end else if (frame_end) begin
            if (frames >= period - 1'b1) begin
                frames  <= '0;
                visible <= ~visible;
            end else begin
                frames <= frames + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcd_seg_map.sv
`timescale 1ns/1ps
module lcd_seg_map
    import lcd_seq_pkg::*;
#(
    parameter int NSEG = 8
) (
    input  logic              running,
    input  logic              half_b,
    input  logic              static_mode,
    input  logic              show,
    input  logic [NSEG-1:0]   row_bits,
    output logic [2*NSEG-1:0] seg_lvl
);
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic lit;
        assign lit = show & row_bits[s];
        always_comb begin
            if (!running) begin
                seg_lvl[2*s +: 2] = LV_GND;
            end else if (lit) begin
                seg_lvl[2*s +: 2] = half_b ? LV_TOP : LV_GND;
            end else if (static_mode) begin
                seg_lvl[2*s +: 2] = half_b ? LV_GND : LV_TOP;
            end else begin
                seg_lvl[2*s +: 2] = half_b ? LV_LO : LV_HI;
            end
        end
    end
endmodule

// File: rtl/lcd_frame_seq.sv
`timescale 1ns/1ps
module lcd_frame_seq
    import lcd_seq_pkg::*;
#(
    parameter int NSEG        = 8,
    parameter int PH_DIV_SLOW = 8,
    parameter int PH_DIV_FAST = 6,
    parameter int BLINK_BASE  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               drive_mode,
    input  logic                     rate_fast,
    input  logic                     bank_alt,
    input  logic                     disp_en,
    input  logic [1:0]               blink_sel,
    input  logic [NUM_BP*NSEG-1:0]   ram_data,
    input  logic                     sync_in,
    output logic                     sync_oe,
    output logic [2*NUM_BP-1:0]      bp_lvl,
    output logic [2*NSEG-1:0]        seg_lvl
);
    seq_state_t      state;
    logic [1:0]      ph;
    logic [1:0]      last_ph;
    logic            tick;
    logic            realign;
    logic            frame_end;
    logic            blink_vis;
    logic [1:0]      row_idx;
    logic [NSEG-1:0] row_bits;
    logic            running;
    logic            half_b;

    assign last_ph   = drive_mode;
    assign realign   = sync_in & ~sync_oe;
    assign running   = (state != ST_OFF);
    assign half_b    = (state == ST_HALF_B);
    assign frame_end = tick & ~realign & half_b & (ph >= last_ph);

    lcd_phase_timer #(
        .DIV_SLOW (PH_DIV_SLOW),
        .DIV_FAST (PH_DIV_FAST)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast    (rate_fast),
        .restart (realign),
        .tick    (tick)
    );

    lcd_blink_gen #(
        .BLINK_BASE (BLINK_BASE)
    ) u_blink (
        .clk       (clk),
        .rst_n     (rst_n),
        .blink_sel (blink_sel),
        .frame_end (frame_end),
        .visible   (blink_vis)
    );

    // State register: phase walk through the two half-frames
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            ph    <= 2'd0;
        end else if (realign) begin
            state <= ST_HALF_B;
            ph    <= last_ph;
        end else if (tick) begin
            unique case (state)
                ST_OFF: begin
                    state <= ST_HALF_A;
                    ph    <= 2'd0;
                end
                ST_HALF_A: begin
                    if (ph >= last_ph) begin
                        state <= ST_HALF_B;
                        ph    <= 2'd0;
                    end else begin
                        ph <= ph + 2'd1;
                    end
                end
                ST_HALF_B: begin
                    if (ph >= last_ph) begin
                        state <= ST_HALF_A;
                        ph    <= 2'd0;
                    end else begin
                        ph <= ph + 2'd1;
                    end
                end
                default: begin
                    state <= ST_OFF;
                    ph    <= 2'd0;
                end
            endcase
        end
    end

    // Row selection with display bank swap
    always_comb begin
        unique case (drive_mode)
            2'd0:    row_idx = bank_alt ? 2'd2 : 2'd0;
            2'd1:    row_idx = bank_alt ? (ph + 2'd2) : ph;
            default: row_idx = ph;
        endcase
    end
    assign row_bits = ram_data[row_idx*NSEG +: NSEG];

    // Output decode: backplanes and sync drive
    always_comb begin
        bp_lvl  = '0;
        sync_oe = 1'b0;
        if (running) begin
            sync_oe = half_b && (ph == last_ph);
            for (int b = 0; b < NUM_BP; b++) begin
                if (2'(b) == ph) begin
                    bp_lvl[2*b +: 2] = half_b ? LV_GND : LV_TOP;
                end else begin
                    bp_lvl[2*b +: 2] = half_b ? LV_HI : LV_LO;
                end
            end
        end
    end

    lcd_seg_map #(
        .NSEG (NSEG)
    ) u_segs (
        .running     (running),
        .half_b      (half_b),
        .static_mode (drive_mode == 2'd0),
        .show        (disp_en & blink_vis),
        .row_bits    (row_bits),
        .seg_lvl     (seg_lvl)
    );
endmodule

// File: rtl/lcd_frame_seq_chk.sv
`timescale 1ns/1ps
module lcd_frame_seq_chk
    import lcd_seq_pkg::*;
#(
    parameter int NSEG = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          drive_mode,
    input logic                disp_en,
    input logic                sync_in,
    input logic                sync_oe,
    input logic [2*NUM_BP-1:0] bp_lvl,
    input logic [2*NSEG-1:0]   seg_lvl,
    input seq_state_t          state,
    input logic [1:0]          ph,
    input logic                tick,
    input logic                realign
);
    logic [NUM_BP-1:0] sel_vec;
    logic              segs_same;

    always_comb begin
        for (int b = 0; b < NUM_BP; b++) begin
            sel_vec[b] = (bp_lvl[2*b +: 2] == ((state == ST_HALF_B) ? LV_GND : LV_TOP));
        end
        segs_same = 1'b1;
        for (int s = 1; s < NSEG; s++) begin
            if (seg_lvl[2*s +: 2] != seg_lvl[1:0]) segs_same = 1'b0;
        end
    end

    p_off_ground_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (bp_lvl == '0 && seg_lvl == '0 && !sync_oe));

    p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !realign) |=> ($stable(ph) && $stable(state)));

    p_one_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF) |-> ($countones(sel_vec) == 1));

    p_blank_uniform_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF && !disp_en) |-> segs_same);

    p_sync_last_bp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_oe |-> (bp_lvl[2*drive_mode +: 2] == LV_GND));

    p_realign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && !sync_oe) |=> sync_oe);
endmodule

bind lcd_frame_seq lcd_frame_seq_chk #(.NSEG(NSEG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .drive_mode (drive_mode),
    .disp_en    (disp_en),
    .sync_in    (sync_in),
    .sync_oe    (sync_oe),
    .bp_lvl     (bp_lvl),
    .seg_lvl    (seg_lvl),
    .state      (state),
    .ph         (ph),
    .tick       (tick),
    .realign    (realign)
);

// File: tb/lcd_frame_seq_tb.sv
`timescale 1ns/1ps
module lcd_frame_seq_tb;
    localparam int NSEG = 8;
    localparam int DS   = 8;
    localparam int DF   = 6;
    localparam int BB   = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          drive_mode = 2'd3;
    logic                rate_fast = 1'b0;
    logic                bank_alt = 1'b0;
    logic                disp_en = 1'b1;
    logic [1:0]          blink_sel = 2'd0;
    logic [4*NSEG-1:0]   ram_data = '0;
    logic                ext_pull = 1'b0;
    logic                sync_oe;
    logic                sync_in;
    logic [7:0]          bp_lvl;
    logic [2*NSEG-1:0]   seg_lvl;

    int ec = 0;
    int n_chk = 0;
    int n_fail = 0;
    int org_c = 0;
    int org_p = 0;
    bit off_ok = 1'b1;

    assign sync_in = sync_oe | ext_pull;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) ec <= 0;
        else        ec <= ec + 1;
    end

    lcd_frame_seq #(
        .NSEG(NSEG), .PH_DIV_SLOW(DS), .PH_DIV_FAST(DF), .BLINK_BASE(BB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .drive_mode(drive_mode), .rate_fast(rate_fast),
        .bank_alt(bank_alt), .disp_en(disp_en), .blink_sel(blink_sel),
        .ram_data(ram_data), .sync_in(sync_in), .sync_oe(sync_oe),
        .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
    );

    task automatic check_now(input string tag);
        int n, dv, p, ph, hb, f, row, per;
        bit off, vis, bit_on;
        logic [7:0] e_bp;
        logic [2*NSEG-1:0] e_seg;
        logic e_sync;
        string t;
        n  = int'(drive_mode) + 1;
        dv = rate_fast ? DF : DS;
        off = off_ok && (ec < org_c);
        e_bp = '0; e_seg = '0; e_sync = 1'b0;
        t = off ? "R1" : tag;
        if (!off) begin
            p  = org_p + (ec - org_c) / dv;
            ph = p % n;
            hb = (p / n) % 2;
            f  = p / (2 * n);
            per = (blink_sel == 0) ? 1 : (BB << (int'(blink_sel) - 1));
            vis = (blink_sel == 0) || (((f / per) % 2) == 0);
            e_sync = (hb == 1) && (ph == n - 1);
            for (int b = 0; b < 4; b++) begin
                if (b == ph) e_bp[2*b +: 2] = (hb == 1) ? 2'd0 : 2'd3;
                else         e_bp[2*b +: 2] = (hb == 1) ? 2'd2 : 2'd1;
            end
            if (drive_mode == 2'd0)      row = bank_alt ? 2 : 0;
            else if (drive_mode == 2'd1) row = bank_alt ? ph + 2 : ph;
            else                         row = ph;
            for (int s = 0; s < NSEG; s++) begin
                bit_on = ram_data[row*NSEG + s] && disp_en && vis;
                if (bit_on)                  e_seg[2*s +: 2] = (hb == 1) ? 2'd3 : 2'd0;
                else if (drive_mode == 2'd0) e_seg[2*s +: 2] = (hb == 1) ? 2'd0 : 2'd3;
                else                         e_seg[2*s +: 2] = (hb == 1) ? 2'd1 : 2'd2;
            end
        end
        n_chk++;
        if (bp_lvl !== e_bp) begin
            n_fail++;
            $display("FAIL %s backplanes at edge %0d: got %h exp %h", t, ec, bp_lvl, e_bp);
        end
        n_chk++;
        if (seg_lvl !== e_seg) begin
            n_fail++;
            $display("FAIL %s segments at edge %0d: got %h exp %h", t, ec, seg_lvl, e_seg);
        end
        n_chk++;
        if (sync_oe !== e_sync) begin
            n_fail++;
            $display("FAIL %s sync_oe at edge %0d: got %b exp %b", t, ec, sync_oe, e_sync);
        end
    endtask

    task automatic start(input logic [1:0] m, input logic rf, input logic ba,
                         input logic en, input logic [1:0] bs, input int pat);
        @(negedge clk);
        rst_n = 1'b0;
        drive_mode = m; rate_fast = rf; bank_alt = ba; disp_en = en; blink_sel = bs;
        for (int r = 0; r < 4; r++) begin
            ram_data[r*NSEG +: NSEG] = 8'(8'hA5 ^ (r * 8'h3B) ^ (pat * 8'h71));
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        org_c = rf ? DF : DS;
        org_p = 0;
        off_ok = 1'b1;
    endtask

    task automatic run(input string tag, input int ncyc);
        check_now(tag);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            check_now(tag);
        end
    endtask

    task automatic realign_test(input logic [1:0] m);
        int n;
        n = int'(m) + 1;
        start(m, 1'b0, 1'b0, 1'b1, 2'd0, 5);
        // land in the second cycle of phase 0, half A of frame 1
        run("R9", org_c + 2 * n * DS + 1);
        ext_pull = 1'b1;
        check_now("R9");
        @(negedge clk);
        ext_pull = 1'b0;
        org_c = ec;
        org_p = 2 * n - 1;
        off_ok = 1'b0;
        run("R9", 3 * n * DS);
    endtask

    initial begin
        // R2, R3, R4, R5: every mode against both rates and both bank settings
        for (int m = 0; m < 4; m++) begin
            for (int rf = 0; rf < 2; rf++) begin
                for (int ba = 0; ba < 2; ba++) begin
                    start(2'(m), 1'(rf), 1'(ba), 1'b1, 2'd0, m * 4 + rf * 2 + ba);
                    run((ba == 1) ? "R5" : ((m == 0) ? "R4" : "R2"), DS + 2 * 2 * 4 * DS + 3);
                end
            end
        end
        // R6: blanking in static and multiplex modes
        start(2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 3);
        run("R6", 3 * 8 * DS);
        start(2'd0, 1'b1, 1'b1, 1'b0, 2'd0, 4);
        run("R6", 6 * 2 * DF);
        // R7: all three blink periods over several toggles
        for (int bs = 1; bs < 4; bs++) begin
            start(2'd1, 1'b1, 1'b0, 1'b1, 2'(bs), 7);
            run("R7", DF + 4 * DF * (BB * 4 * 2 + 3));
        end
        // R8 is checked on every cycle; R9 realignment in static and 1:4
        realign_test(2'd0);
        realign_test(2'd3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule